// File: doc/BRIEF.md
# MDIO Management Controller

This block reads and writes PHY registers over the two-wire management bus. The bus has a clock, MDC, and an open-drain data line, MDIO. The host first sets a control word, which holds the MDC divisor and a flag that drops the preamble. For a write, it then loads the 16-bit data register. Last, it issues a packed command word. From the cycle after the command is accepted, `busy` stays high until the whole frame has gone out. After a read, the 16 bits returned by the PHY sit in the data register once `busy` falls.

The block builds clause-22 frames, sent MSB first:
- 32 ones of preamble, unless the preamble is suppressed;
- start code 01;
- opcode 10 for a read or 01 for a write;
- 5-bit PHY address, then 5-bit register address;
- a two-bit turnaround;
- 16 data bits.

MDC idles low. Output data changes only when MDC falls, and read data is sampled on the MDC rising edge. MDIO is driven through separate value and enable pins and read through its own input pin.

None of the ports carry a stream, so all of them are plain control and status pins with no valid/ready handshake. The block applies no back-pressure. A command that arrives while `busy` is high is simply dropped. The host must poll `busy` before it issues the next command.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset:
  - `busy`, `mdc` and `mdio_oe` are 0;
  - `data_out` is 0;
  - the divisor register holds 32 and preamble suppression is off.
- R2: The command word has the register address in bits 4:0, the PHY address in bits 9:5, a write flag in bit 10 and a read flag in bit 11. A `cmd_we` pulse with exactly one flag set starts a frame. With neither flag set, or both, the command is ignored and `busy` stays low.
- R3: A frame consists of:
  - 32 ones of preamble (unless suppressed);
  - 01;
  - the opcode (10 read, 01 write);
  - PHY address, then register address;
  - turnaround 10 for a write;
  - 16 data bits.
  
  All fields are MSB first, and the bit count is 64, or 32 without the preamble.
- R4: When the suppress bit (`ctl_presup`) is set at the time a command is accepted, the preamble is left out and the frame begins with the start code.
- R5: The MDC period is the effective divisor E, where E is the divisor register value, or 2 if that value is 0 or 1.
  - The low phase lasts E - floor(E/2) cycles and the high phase floor(E/2) cycles.
  - The divisor is captured when a command is accepted, so a control write during a frame only affects later frames.
- R6: MDIO value and enable change only in the cycle in which MDC falls. A write frame drives every bit. A read frame releases MDIO (`mdio_oe`=0) for the turnaround and the 16 data bits.
- R7: A read samples `mdio_i` at each MDC rising edge of the 16 data bits, MSB first. The value appears on `data_out` in the first cycle in which `busy` is low.
- R8: `busy` is high from the cycle after the command is accepted until the cycle in which MDC falls at the end of the last bit. While `busy` is low, MDC is low and MDIO is released.
- R9: While `busy` is high, commands and data-register writes are ignored.
- R10: If `data_we` and an accepted write command fall in the same cycle, the frame carries the new `data_in` value, and the data register takes it too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_div | input | DIV_W | MDC divisor value |
| ctl_presup | input | 1 | Preamble suppress flag |
| data_we | input | 1 | Write strobe for the data register |
| data_in | input | 16 | Value for the data register |
| cmd_we | input | 1 | Command strobe |
| cmd_word | input | 12 | Packed command (R2 layout) |
| data_out | output | 16 | Data register contents |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Two host actions can fall in the same cycle and must be resolved with a fixed order.

- **Data write and command in one cycle.** The bench raises `data_we` together with a write command. It judges the serialised data bits against the new value and not the old one.
- **Actions while busy.** In the middle of a frame, the bench pulses a read command, a data write and a control write together. A scoreboard that expects exactly one frame reports any extra frame. The bench then checks three things:
  - the data register still holds the written value;
  - the running frame keeps its original MDC phase lengths;
  - the next frame uses the new divisor.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int HDR_BITS   = 4 + 2 * ADDR_W;
  localparam int TA_BITS    = 2;
  localparam int BODY_BITS  = HDR_BITS + TA_BITS + DATA_W;
  localparam int FRAME_BITS = PRE_BITS + BODY_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int CMD_W      = 2 * ADDR_W + 2;
  localparam int CMD_REG_LSB = 0;
  localparam int CMD_PHY_LSB = ADDR_W;
  localparam int CMD_WR_BIT  = 2 * ADDR_W;
  localparam int CMD_RD_BIT  = 2 * ADDR_W + 1;

  localparam logic [1:0] ST_CODE  = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] TA_WRITE = 2'b10;
  localparam logic [1:0] TA_READ  = 2'b00;

  typedef struct packed {
    logic              valid;
    logic              is_read;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
  } mgmt_cmd_t;
endpackage

// File: rtl/mdio_cmd_decode.sv
module mdio_cmd_decode
  import mdio_mgmt_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_word,
  output mgmt_cmd_t        cmd
);
  logic rd_flag;
  logic wr_flag;

  always_comb begin
    rd_flag     = cmd_word[CMD_RD_BIT];
    wr_flag     = cmd_word[CMD_WR_BIT];
    cmd.valid   = rd_flag ^ wr_flag;
    cmd.is_read = rd_flag;
    cmd.phy     = cmd_word[CMD_PHY_LSB +: ADDR_W];
    cmd.regad   = cmd_word[CMD_REG_LSB +: ADDR_W];
  end
endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             mdc,
  output logic             rise_ev,
  output logic             fall_ev
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  logic [DIV_W-1:0] eff_div;
  logic [DIV_W-1:0] lo_len;
  logic [DIV_W-1:0] hi_len;
  logic [DIV_W-1:0] lo_q;
  logic [DIV_W-1:0] hi_q;
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;

  always_comb begin
    eff_div = (div_in < MIN_DIV) ? MIN_DIV : div_in;
    hi_len  = eff_div >> 1;
    lo_len  = eff_div - hi_len;
  end

  assign rise_ev = run & ~mdc_q & (cnt_q == lo_q - 1'b1);
  assign fall_ev = run &  mdc_q & (cnt_q == hi_q - 1'b1);
  assign mdc     = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_q <= 1'b0;
      cnt_q <= '0;
      lo_q  <= DIV_W'(1);
      hi_q  <= DIV_W'(1);
    end else if (start) begin
      mdc_q <= 1'b0;
      cnt_q <= '0;
      lo_q  <= lo_len;
      hi_q  <= hi_len;
    end else if (run) begin
      if (rise_ev) begin
        mdc_q <= 1'b1;
        cnt_q <= '0;
      end else if (fall_ev) begin
        mdc_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      mdc_q <= 1'b0;
      cnt_q <= '0;
    end
  end

  // R5
  phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < (mdc_q ? hi_q : lo_q)));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rd,
  input  logic [ADDR_W-1:0] start_phy,
  input  logic [ADDR_W-1:0] start_reg,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              start_presup,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              mdio_i,
  output logic              busy,
  output logic              is_rd,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [CNT_W-1:0] LAST_FULL  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(BODY_BITS - 1);
  localparam logic [CNT_W-1:0] RELEASE_AT = CNT_W'(TA_BITS + DATA_W);
  localparam logic [CNT_W-1:0] DATA_AT    = CNT_W'(DATA_W);

  logic [FRAME_BITS-1:0] sh_q;
  logic [CNT_W-1:0]      left_q;
  logic                  busy_q;
  logic                  rd_q;
  logic [DATA_W-1:0]     cap_q;
  logic [BODY_BITS-1:0]  body;

  always_comb begin
    body = {ST_CODE,
            start_rd ? OP_READ : OP_WRITE,
            start_phy,
            start_reg,
            start_rd ? TA_READ : TA_WRITE,
            start_rd ? {DATA_W{1'b0}} : start_wdata};
  end

  assign done    = busy_q & fall_ev & (left_q == '0);
  assign mdio_oe = busy_q & (~rd_q | (left_q >= RELEASE_AT));
  assign mdio_o  = sh_q[FRAME_BITS-1] & mdio_oe;
  assign busy    = busy_q;
  assign is_rd   = rd_q;
  assign rd_data = cap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      cap_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      rd_q   <= start_rd;
      cap_q  <= '0;
      if (start_presup) begin
        sh_q   <= {body, {PRE_BITS{1'b0}}};
        left_q <= LAST_SHORT;
      end else begin
        sh_q   <= {{PRE_BITS{1'b1}}, body};
        left_q <= LAST_FULL;
      end
    end else if (busy_q) begin
      if (rise_ev && rd_q && (left_q < DATA_AT)) begin
        cap_q <= {cap_q[DATA_W-2:0], mdio_i};
      end
      if (fall_ev) begin
        if (left_q == '0) begin
          busy_q <= 1'b0;
        end else begin
          left_q <= left_q - 1'b1;
          sh_q   <= sh_q << 1;
        end
      end
    end
  end

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fall_ev) |=> ($stable(mdio_o) && $stable(mdio_oe)));

  // R8
  release_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy_q && !mdio_oe));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int DIV_DEFAULT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [DIV_W-1:0]  ctl_div,
  input  logic              ctl_presup,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_in,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic [DATA_W-1:0] data_out,
  output logic              busy,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  mgmt_cmd_t         dec;
  logic [DIV_W-1:0]  div_q;
  logic              presup_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] wdata_sel;
  logic              accept;
  logic              eng_busy;
  logic              eng_rd;
  logic              eng_done;
  logic [DATA_W-1:0] eng_rdata;
  logic              rise_ev;
  logic              fall_ev;

  mdio_cmd_decode u_dec (
    .cmd_word (cmd_word),
    .cmd      (dec)
  );

  assign accept    = cmd_we & dec.valid & ~eng_busy;
  assign wdata_sel = data_we ? data_in : data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q    <= DIV_W'(DIV_DEFAULT);
      presup_q <= 1'b0;
    end else if (ctl_we) begin
      div_q    <= ctl_div;
      presup_q <= ctl_presup;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (eng_done && eng_rd) begin
      data_q <= eng_rdata;
    end else if (data_we && !eng_busy) begin
      data_q <= data_in;
    end
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .run     (eng_busy),
    .div_in  (div_q),
    .mdc     (mdc),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  mdio_frame_engine u_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (accept),
    .start_rd     (dec.is_read),
    .start_phy    (dec.phy),
    .start_reg    (dec.regad),
    .start_wdata  (wdata_sel),
    .start_presup (presup_q),
    .rise_ev      (rise_ev),
    .fall_ev      (fall_ev),
    .mdio_i       (mdio_i),
    .busy         (eng_busy),
    .is_rd        (eng_rd),
    .mdio_o       (mdio_o),
    .mdio_oe      (mdio_oe),
    .done         (eng_done),
    .rd_data      (eng_rdata)
  );

  assign busy     = eng_busy;
  assign data_out = data_q;

  // R2
  busy_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_we));

  // R9
  data_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && data_we && !eng_done) |=> $stable(data_q));

  // R8
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
endmodule

// File: tb/mdio_mgmt_ctrl_tb_top.sv
module mdio_mgmt_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] vec;
    int          len;
    bit          rd;
    logic [15:0] rdval;
    int          lo;
    int          hi;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_div = 8'd0;
  logic        ctl_presup = 1'b0;
  logic        data_we = 1'b0;
  logic [15:0] data_in = 16'h0;
  logic        cmd_we = 1'b0;
  logic [11:0] cmd_word = 12'h0;
  logic [15:0] data_out;
  logic        busy;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  exp_t exp_q[$];

  int          m_div = 32;
  bit          m_presup = 0;
  logic [15:0] m_data = 16'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_div(ctl_div),
    .ctl_presup(ctl_presup), .data_we(data_we), .data_in(data_in),
    .cmd_we(cmd_we), .cmd_word(cmd_word), .data_out(data_out),
    .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic exp_t build(input bit rd, input logic [4:0] phy,
      input logic [4:0] rg, input logic [15:0] d, input bit presup,
      input int dv, input logic [15:0] rdval);
    exp_t e;
    logic [31:0] body;
    int ef;
    body = {2'b01, rd ? 2'b10 : 2'b01, phy, rg, rd ? 2'b00 : 2'b10,
            rd ? 16'h0 : d};
    e.len = presup ? 32 : 64;
    e.vec = presup ? {32'h0, body} : {32'hFFFF_FFFF, body};
    e.rd = rd;
    e.rdval = rdval;
    ef = (dv < 2) ? 2 : dv;
    e.hi = ef / 2;
    e.lo = ef - ef / 2;
    return e;
  endfunction

  // Monitor and PHY model: collects bits at MDC rises, checks phases.
  bit          in_txn = 0;
  bit          have_cur = 0;
  int          nb = 0;
  int          run_len = 0;
  int          ph_bad = 0;
  logic        last_mdc = 0;
  logic [63:0] got_b = '0;
  logic [63:0] got_oe = '0;
  exp_t        cur;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && busy) begin
        if (!in_txn) begin
          in_txn = 1; nb = 0; run_len = 1; last_mdc = mdc; ph_bad = 0;
          got_b = '0; got_oe = '0; mdio_i = 1'b1;
          if (exp_q.size() == 0) begin
            have_cur = 0;
            check(0, "R9", "frame with no accepted command", 1, 0);
          end else begin
            cur = exp_q.pop_front();
            have_cur = 1;
          end
        end else if (mdc == last_mdc) begin
          run_len++;
        end else begin
          if (have_cur) begin
            if (last_mdc) begin
              if (run_len != cur.hi) ph_bad++;
            end else if (run_len != cur.lo) ph_bad++;
          end
          if (mdc) begin
            if (nb < 64) begin
              got_b[nb] = mdio_o;
              got_oe[nb] = mdio_oe;
            end
            nb++;
          end else if (have_cur && cur.rd && nb >= cur.len - 16 && nb < cur.len) begin
            mdio_i = cur.rdval[15 - (nb - (cur.len - 16))];
          end
          run_len = 1;
          last_mdc = mdc;
        end
      end else if (in_txn) begin
        in_txn = 0;
        mdio_i = 1'b1;
        if (have_cur) begin
          bit bit_ok;
          bit oe_ok;
          logic eoe;
          logic [63:0] exp_sent;
          bit_ok = 1; oe_ok = 1; exp_sent = '0;
          if (!last_mdc || run_len != cur.hi) ph_bad++;
          for (int j = 0; j < cur.len; j++) begin
            eoe = cur.rd ? (j < cur.len - 18) : 1'b1;
            exp_sent[j] = cur.vec[cur.len - 1 - j];
            if (got_oe[j] !== eoe) oe_ok = 0;
            if (eoe && got_b[j] !== exp_sent[j]) bit_ok = 0;
          end
          check(nb == cur.len, "R3", "bit count", 64'(nb), 64'(cur.len));
          check(bit_ok, "R3", "frame bits (bit0 = first sent)", got_b, exp_sent);
          check(oe_ok, "R6", "output enable per bit", got_oe, 64'(cur.len));
          check(ph_bad == 0, "R5", "MDC phase lengths, bad count",
                64'(ph_bad), 64'(0));
          check(!mdio_oe && !mdc, "R8", "idle after frame", {mdio_oe, mdc}, 0);
          if (cur.rd)
            check(data_out == cur.rdval, "R7", "read data", data_out, cur.rdval);
        end
      end
    end
  end

  task automatic set_ctl(input int dv, input bit ps);
    @(negedge clk);
    ctl_we = 1; ctl_div = 8'(dv); ctl_presup = ps;
    @(negedge clk);
    ctl_we = 0;
    m_div = dv; m_presup = ps;
  endtask

  task automatic set_data(input logic [15:0] d);
    @(negedge clk);
    data_we = 1; data_in = d;
    @(negedge clk);
    data_we = 0;
    m_data = d;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Driver: pushes the expected frame, then issues the command.
  task automatic run_txn(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] rdval, input bit poke);
    exp_q.push_back(build(rd, phy, rg, m_data, m_presup, m_div, rdval));
    @(negedge clk);
    cmd_we = 1; cmd_word = {rd, ~rd, phy, rg};
    @(negedge clk);
    cmd_we = 0;
    check(busy == 1'b1, "R8", "busy one cycle after command", busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      cmd_we = 1; cmd_word = {1'b1, 1'b0, 5'h1F, 5'h1F};
      data_we = 1; data_in = 16'hFFFF;
      ctl_we = 1; ctl_div = 8'd2; ctl_presup = m_presup;
      @(negedge clk);
      cmd_we = 0; data_we = 0; ctl_we = 0;
    end
    wait_idle();
    if (rd) m_data = rdval;
    check(data_out == m_data, "R9", "data register after frame", data_out, m_data);
    if (poke) m_div = 2;
  endtask

  task automatic bad_cmd(input logic [11:0] w);
    @(negedge clk);
    cmd_we = 1; cmd_word = w;
    @(negedge clk);
    cmd_we = 0;
    repeat (3) @(negedge clk);
    check(!busy && !mdio_oe, "R2", "invalid opcode flags ignored", {busy, mdio_oe}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog expired act=busy exp=idle");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !mdc && !mdio_oe, "R1", "control outputs after reset",
          {busy, mdc, mdio_oe}, 0);
    check(data_out == 16'h0, "R1", "data register after reset", data_out, 0);

    // R1 R3 default divisor 32, full preamble write
    set_data(16'hA5C3);
    run_txn(0, 5'h11, 5'h04, 16'h0, 0);
    // R7 read with preamble
    run_txn(1, 5'h01, 5'h02, 16'h1234, 0);
    // R4 R5 divisor 0 treated as 2, suppressed preamble
    set_ctl(0, 1);
    run_txn(1, 5'h0A, 5'h1B, 16'hBEEF, 0);
    // R5 divisor 1
    set_ctl(1, 1);
    set_data(16'h0F0F);
    run_txn(0, 5'h1F, 5'h00, 16'h0, 0);
    // R5 odd divisor 5
    set_ctl(5, 0);
    run_txn(1, 5'h00, 5'h1F, 16'h8001, 0);
    // R2 invalid flag combinations
    bad_cmd(12'h023);
    bad_cmd(12'hC23);
    // R9 command, data and control writes while busy
    set_ctl(4, 1);
    set_data(16'h3C96);
    run_txn(0, 5'h05, 5'h06, 16'h0, 1);
    repeat (10) @(negedge clk);
    check(!busy, "R9", "no frame from command issued while busy", busy, 0);
    // R5 new divisor applies to the next frame
    run_txn(1, 5'h07, 5'h08, 16'h7E11, 0);
    // R10 data write and command in the same cycle
    m_data = 16'h5A5A;
    exp_q.push_back(build(0, 5'h12, 5'h13, 16'h5A5A, m_presup, m_div, 16'h0));
    @(negedge clk);
    data_we = 1; data_in = 16'h5A5A;
    cmd_we = 1; cmd_word = {1'b0, 1'b1, 5'h12, 5'h13};
    @(negedge clk);
    data_we = 0; cmd_we = 0;
    wait_idle();
    check(data_out == 16'h5A5A, "R10", "data register takes same-cycle value",
          data_out, 16'h5A5A);
    check(exp_q.size() == 0, "R3", "all expected frames observed",
          64'(exp_q.size()), 0);
    finish_up();
  end
endmodule